// File: doc/BRIEF.md
# Indexed RAM Download Port

This block is a byte-wide host register port. Software uses it to fill an on-chip configuration RAM through a single shared data register. When the port is idle, a byte written to that register is taken as a command. One command value starts a download session and another clears a key-enable flag. After the download command, the next two bytes give a 16-bit start address, low byte first. Every later byte written to the same register goes into RAM at the current address, and the address then advances by one. In the data phase, a read of the register returns the RAM byte at the current address and also advances the address.

Software closes a session by writing one of two terminator values to a separate end register. The port then returns to the idle command state and raises a single-cycle refresh pulse, which tells downstream logic that the configuration data has changed.

An index register is also provided. Reads of it return the stored value with the upper nibble forced high, so that driver software can identify the device family.

The RAM itself sits outside the block. The port drives its address, its write strobe and its read strobe, and takes back a combinational read byte.

Top module: `cfg_ram_loader`

## Requirements
- R1: After reset the port is in the idle command state, the start address is 0x0000, `key_en` is 1, `cfg_refresh` is 0 and the index register is 0x00. `key_en` never rises except through reset.
- R2: In the command state, writing 0xAA to register 5 starts a download. Any command value other than 0xAA or 0x55 is ignored: it causes no RAM write and leaves `ram_addr` unchanged.
- R3: In the command state, writing 0x55 to register 5 clears `key_en`. No other command value changes `key_en`.
- R4: After 0xAA, the first byte written to register 5 sets address bits 7:0 and clears bits 15:8. The second byte sets bits 15:8. Each later write to register 5 pulses `ram_we` with `ram_addr` equal to the current address and `ram_wdata` equal to the byte written.
- R5: Each data-phase write or read increments the address by one, and the address wraps from 0xFFFF to 0x0000.
- R6: In the data phase, a read of register 5 returns `ram_rdata` for the current address on `host_rdata` in the same cycle, pulses `ram_re`, and then advances the address.
- R7: Outside the data phase, a read of register 5 returns 0x00, does not pulse `ram_re` and leaves the address unchanged.
- R8: Writing 0x00 or 0x40 to register 6, in any state, returns the port to the command state. `cfg_refresh` is then high for exactly the one cycle that follows the write. Any other value written to register 6 is ignored, so the session continues and no pulse is produced.
- R9: A write to register 3 stores the index byte. A read of register 3 returns that byte with bits 7:4 forced to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Register index (low three host address bits) |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, combinational during `host_rd` |
| ram_addr | output | 16 | Current RAM address |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe (address advances after it) |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte, combinational from `ram_addr` |
| key_en | output | 1 | Key-enable flag |
| cfg_refresh | output | 1 | Single-cycle configuration-updated pulse |

## Verification
The assertions assume that `host_wr` and `host_rd` are never high in the same cycle. They also assume that each strobe stands for exactly one access per clock. They further assume that `ram_rdata` is valid in the same cycle as `ram_addr`. The bench meets these assumptions by driving each access as a single strobe pulse between falling edges, with an idle gap after it. Its RAM model answers reads combinationally and captures writes at the rising edge. The bench never sends two terminators back to back, so the single-cycle width of the refresh pulse can be checked without ambiguity.

// File: rtl/cfg_dl_pkg.sv
package cfg_dl_pkg;
    typedef enum logic [1:0] {
        ST_CMD  = 2'd0,
        ST_ALO  = 2'd1,
        ST_AHI  = 2'd2,
        ST_DATA = 2'd3
    } dl_state_e;

    localparam logic [2:0] REG_IDX  = 3'd3;
    localparam logic [2:0] REG_PORT = 3'd5;
    localparam logic [2:0] REG_END  = 3'd6;

    localparam logic [7:0] CMD_DOWNLOAD = 8'hAA;
    localparam logic [7:0] CMD_KEY_OFF  = 8'h55;
    localparam logic [7:0] END_CODE_A   = 8'h00;
    localparam logic [7:0] END_CODE_B   = 8'h40;
    localparam logic [7:0] IDX_FAMILY   = 8'hF0;
endpackage

// File: rtl/cfg_dl_seq.sv
module cfg_dl_seq
    import cfg_dl_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    host_addr,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [7:0]    host_wdata,
    output logic [AW-1:0] addr_o,
    output logic          ram_we,
    output logic          ram_re,
    output logic          key_en,
    output logic          refresh,
    output logic [7:0]    idx_o
);
    localparam int HI_SHIFT = 8;

    typedef struct packed {
        dl_state_e     state;
        logic [AW-1:0] addr;
        logic          key_en;
        logic          refresh;
        logic [7:0]    idx;
    } seq_t;

    seq_t q, d;

    logic port_wr, port_rd, end_hit;

    always_comb begin
        port_wr = host_wr && (host_addr == REG_PORT);
        port_rd = host_rd && !host_wr && (host_addr == REG_PORT);
        end_hit = host_wr && (host_addr == REG_END) &&
                  ((host_wdata == END_CODE_A) || (host_wdata == END_CODE_B));
        ram_we  = port_wr && (q.state == ST_DATA);
        ram_re  = port_rd && (q.state == ST_DATA);

        d         = q;
        d.refresh = 1'b0;

        unique case (q.state)
            ST_CMD: if (port_wr) begin
                if (host_wdata == CMD_DOWNLOAD)     d.state  = ST_ALO;
                else if (host_wdata == CMD_KEY_OFF) d.key_en = 1'b0;
            end
            ST_ALO: if (port_wr) begin
                d.addr  = AW'(host_wdata);
                d.state = ST_AHI;
            end
            ST_AHI: if (port_wr) begin
                d.addr  = q.addr | (AW'(host_wdata) << HI_SHIFT);
                d.state = ST_DATA;
            end
            ST_DATA: if (ram_we || ram_re) begin
                d.addr = q.addr + AW'(1);
            end
            default: d.state = ST_CMD;
        endcase

        if (end_hit) begin
            d.state   = ST_CMD;
            d.refresh = 1'b1;
        end

        if (host_wr && (host_addr == REG_IDX)) d.idx = host_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state   <= ST_CMD;
            q.addr    <= '0;
            q.key_en  <= 1'b1;
            q.refresh <= 1'b0;
            q.idx     <= '0;
        end else begin
            q <= d;
        end
    end

    assign addr_o  = q.addr;
    assign key_en  = q.key_en;
    assign refresh = q.refresh;
    assign idx_o   = q.idx;
endmodule

// File: rtl/cfg_dl_rdmux.sv
module cfg_dl_rdmux
    import cfg_dl_pkg::*;
(
    input  logic [2:0] host_addr,
    input  logic       host_rd,
    input  logic       ram_re,
    input  logic [7:0] ram_rdata,
    input  logic [7:0] idx,
    output logic [7:0] rdata
);
    always_comb begin
        rdata = 8'h00;
        if (host_rd) begin
            if (host_addr == REG_IDX)                 rdata = idx | IDX_FAMILY;
            else if (host_addr == REG_PORT && ram_re) rdata = ram_rdata;
        end
    end
endmodule

// File: rtl/cfg_ram_loader.sv
module cfg_ram_loader #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    host_addr,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    output logic [AW-1:0] ram_addr,
    output logic          ram_we,
    output logic          ram_re,
    output logic [7:0]    ram_wdata,
    input  logic [7:0]    ram_rdata,
    output logic          key_en,
    output logic          cfg_refresh
);
    logic [7:0] idx_w;

    cfg_dl_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .addr_o     (ram_addr),
        .ram_we     (ram_we),
        .ram_re     (ram_re),
        .key_en     (key_en),
        .refresh    (cfg_refresh),
        .idx_o      (idx_w)
    );

    cfg_dl_rdmux u_rdmux (
        .host_addr (host_addr),
        .host_rd   (host_rd),
        .ram_re    (ram_re),
        .ram_rdata (ram_rdata),
        .idx       (idx_w),
        .rdata     (host_rdata)
    );

    assign ram_wdata = host_wdata;
endmodule

// File: rtl/cfg_ram_loader_chk.sv
module cfg_ram_loader_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    host_addr,
    input logic          host_wr,
    input logic          host_rd,
    input logic [7:0]    host_wdata,
    input logic [7:0]    host_rdata,
    input logic [AW-1:0] ram_addr,
    input logic          ram_we,
    input logic          ram_re,
    input logic          key_en,
    input logic          cfg_refresh
);
    assert_key_no_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(key_en));

    assert_key_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(key_en) |-> $past(host_wr && host_addr == 3'd5 && host_wdata == 8'h55));

    assert_we_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (host_wr && host_addr == 3'd5));

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we || ram_re) |=> (ram_addr == $past(ram_addr) + AW'(1)));

    assert_rd_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re));

    assert_refresh_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_refresh) |-> $past(host_wr && host_addr == 3'd6 &&
                                     (host_wdata == 8'h00 || host_wdata == 8'h40)));

    assert_idx_family_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 3'd3) |-> (host_rdata[7:4] == 4'hF));
endmodule

bind cfg_ram_loader cfg_ram_loader_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_addr   (host_addr),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .ram_addr    (ram_addr),
    .ram_we      (ram_we),
    .ram_re      (ram_re),
    .key_en      (key_en),
    .cfg_refresh (cfg_refresh)
);

// File: tb/tb_cfg_ram_loader.sv
module tb_cfg_ram_loader;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  host_addr;
    logic        host_wr, host_rd;
    logic [7:0]  host_wdata, host_rdata;
    logic [15:0] ram_addr;
    logic        ram_we, ram_re;
    logic [7:0]  ram_wdata, ram_rdata;
    logic        key_en, cfg_refresh;

    logic [7:0] mem [0:255];
    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] rd_cap;
    logic       we_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_ram_loader dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_re(ram_re),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .key_en(key_en),
        .cfg_refresh(cfg_refresh)
    );

    always_ff @(posedge clk) if (ram_we) mem[ram_addr[7:0]] <= ram_wdata;
    assign ram_rdata = mem[ram_addr[7:0]];

    // vector: {is_read, reg, wdata, expected rdata, expected ram_addr afterwards}
    localparam int NV = 12;
    localparam logic [35:0] VEC [0:NV-1] = '{
        {1'b0, 3'd5, 8'hAA, 8'h00, 16'h0000},
        {1'b0, 3'd5, 8'h34, 8'h00, 16'h0034},
        {1'b0, 3'd5, 8'h12, 8'h00, 16'h1234},
        {1'b0, 3'd5, 8'hA1, 8'h00, 16'h1235},
        {1'b0, 3'd5, 8'hB2, 8'h00, 16'h1236},
        {1'b0, 3'd6, 8'h00, 8'h00, 16'h1236},
        {1'b0, 3'd5, 8'hAA, 8'h00, 16'h1236},
        {1'b0, 3'd5, 8'h34, 8'h00, 16'h0034},
        {1'b0, 3'd5, 8'h12, 8'h00, 16'h1234},
        {1'b1, 3'd5, 8'h00, 8'hA1, 16'h1235},
        {1'b1, 3'd5, 8'h00, 8'hB2, 16'h1236},
        {1'b0, 3'd6, 8'h40, 8'h00, 16'h1236}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one access: drive at falling edge, capture read data mid-cycle, release after rising edge
    task automatic access(input logic rd, input logic [2:0] r, input logic [7:0] v);
        @(negedge clk);
        host_addr = r; host_wr = !rd; host_rd = rd; host_wdata = v;
        #(CLK_PERIOD/4);
        rd_cap  = host_rdata;
        we_seen = ram_we;
        @(posedge clk);
        #1;
        host_wr = 1'b0; host_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        host_addr = '0; host_wr = 0; host_rd = 0; host_wdata = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1 reset state
        check("R1 addr", ram_addr, 16'h0000);
        check("R1 key_en", {15'd0, key_en}, 16'd1);
        check("R1 refresh", {15'd0, cfg_refresh}, 16'd0);
        access(1'b1, 3'd3, 8'h00);
        check("R1 idx", {8'd0, rd_cap}, 16'h00F0);

        // table walk: R4 writes, R6 reads, R5 increment, R8 terminators
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][35], VEC[i][34:32], VEC[i][31:24]);
            if (VEC[i][35]) check("R6 rdata", {8'd0, rd_cap}, {8'd0, VEC[i][23:16]});
            check("R5 addr", ram_addr, VEC[i][15:0]);
            if (VEC[i][34:32] == 3'd6) begin
                check("R8 pulse", {15'd0, cfg_refresh}, 16'd1);
                @(posedge clk); #1;
                check("R8 one cycle", {15'd0, cfg_refresh}, 16'd0);
            end
        end
        check("R4 mem34", {8'd0, mem[8'h34]}, 16'h00A1);
        check("R4 mem35", {8'd0, mem[8'h35]}, 16'h00B2);

        // R2/R3: unknown command ignored
        access(1'b0, 3'd5, 8'h77);
        check("R3 key kept", {15'd0, key_en}, 16'd1);
        access(1'b0, 3'd5, 8'h10);
        check("R2 no ram write", {15'd0, we_seen}, 16'd0);
        check("R2 addr kept", ram_addr, 16'h1236);

        // R7: read in command state
        access(1'b1, 3'd5, 8'h00);
        check("R7 rdata", {8'd0, rd_cap}, 16'h0000);
        check("R7 addr kept", ram_addr, 16'h1236);

        // R3: key off
        access(1'b0, 3'd5, 8'h55);
        check("R3 key cleared", {15'd0, key_en}, 16'd0);

        // R7 read during address phase, then R5 wrap
        access(1'b0, 3'd5, 8'hAA);
        access(1'b1, 3'd5, 8'h00);
        check("R7 alo rdata", {8'd0, rd_cap}, 16'h0000);
        access(1'b0, 3'd5, 8'hFF);
        access(1'b0, 3'd5, 8'hFF);
        check("R4 addr", ram_addr, 16'hFFFF);
        // R8: non-terminator value ignored
        access(1'b0, 3'd6, 8'h41);
        check("R8 no pulse", {15'd0, cfg_refresh}, 16'd0);
        access(1'b0, 3'd5, 8'h5A);
        check("R8 still data", {15'd0, we_seen}, 16'd1);
        check("R5 wrap", ram_addr, 16'h0000);
        check("R4 memFF", {8'd0, mem[8'hFF]}, 16'h005A);
        access(1'b0, 3'd6, 8'h00);

        // R9 index register
        access(1'b0, 3'd3, 8'h05);
        access(1'b1, 3'd3, 8'h00);
        check("R9 idx", {8'd0, rd_cap}, 16'h00F5);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule